// File: doc/BRIEF.md
# EPP Host Cycle Controller

This block is the host end of an Enhanced Parallel Port link. A local client asks for one transfer at a time with a single-cycle start pulse. The request says whether the transfer is an address or a data transfer, whether it reads or writes, and which byte to write. The controller then runs the port handshake on an 8-bit bidirectional bus. It drives the active-low write qualifier, the two active-low strobes and the active-low peripheral reset. It also controls the output enable of the bus drivers.

Pacing comes from a two-phase interlock on the peripheral's active-low wait line. The wait line must be low (peripheral ready) before a strobe is raised. It must go high (transfer acknowledged) before the strobe is dropped. It must fall again (bus released) before the controller changes direction or releases its drivers. A programmable limit bounds every wait. If the limit expires, the controller sets a sticky timeout flag, drops the strobe, releases the bus and goes back to idle. The interrupt line is synchronised, and each rising edge produces a one-cycle pulse for the client.

Top module: `epp_host_ctrl`

## Requirements
- R1: While rst_n is low and after its release, both strobes, the write qualifier and nreset_o behave as follows: both strobes are high, nwrite_o is high, pd_oe is low, busy and timeout_flag are low, and nreset_o is low during reset.
- R2: A start pulse is taken only when the controller is idle and the synchronised wait line is low. A start pulse given while busy, or while the wait line is high, starts nothing and leaves the current transfer unchanged.
- R3: In a write (req_read=0), the cycle after the start is accepted shows nwrite_o low, pd_oe high and pd_o equal to the request byte, with both strobes still high. The strobe falls on the following cycle. pd_o stays constant while the strobe is low.
- R4: In a read (req_read=1), the setup cycle shows nwrite_o high and pd_oe low before the strobe falls. After the wait line is seen high, pd_i is captured into rd_data, done pulses for exactly one cycle, and the strobe rises.
- R5: req_addr=1 selects naddrstb_o and req_addr=0 selects ndatastb_o. Only the selected strobe goes low, and the two are never low together.
- R6: After the strobe rises, nwrite_o and pd_oe keep their cycle values until the synchronised wait line is low again. Then the controller goes idle with nwrite_o high and pd_oe low. nwrite_o and pd_oe change only in a cycle that follows one with both strobes high.
- R7: If no acknowledge arrives, the strobe stays low for exactly timeout_limit cycles. The controller then raises timeout_flag, raises the strobe, releases the bus and goes idle, with no done pulse.
- R8: If the wait line stays high for timeout_limit cycles after the strobe has risen, timeout_flag is set and the controller goes idle.
- R9: A timeout_limit of zero disables the timeout, so a wait of any length completes normally.
- R10: timeout_flag stays set until the next accepted start, which clears it.
- R11: Each rising edge of intr_i gives exactly one single-cycle intr_pulse. A level held high gives no further pulses.
- R12: nreset_o equals the inverse of periph_rst_req delayed by one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | One-cycle request to begin a transfer |
| req_addr | input | 1 | 1 = address transfer, 0 = data transfer |
| req_read | input | 1 | 1 = read, 0 = write |
| req_wdata | input | 8 | Byte to write |
| timeout_limit | input | 8 | Wait limit in cycles, 0 disables |
| periph_rst_req | input | 1 | 1 requests the peripheral reset |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle pulse on acknowledge |
| rd_data | output | 8 | Last byte read |
| timeout_flag | output | 1 | Sticky timeout indication |
| intr_pulse | output | 1 | One-cycle pulse per interrupt rising edge |
| nwrite_o | output | 1 | Active-low write qualifier |
| ndatastb_o | output | 1 | Active-low data strobe |
| naddrstb_o | output | 1 | Active-low address strobe |
| nreset_o | output | 1 | Active-low peripheral reset |
| pd_o | output | 8 | Bus output value |
| pd_oe | output | 1 | Bus output enable |
| pd_i | input | 8 | Bus input value |
| nwait_i | input | 1 | Active-low wait from the peripheral |
| intr_i | input | 1 | Interrupt from the peripheral |

## Verification
The assertions take for granted that timeout_limit does not change while a transfer is in progress. They also assume the peripheral holds pd_i steady from before it raises the wait line until the strobe has risen. The stimulus changes the limit only between transfers. It loads pd_i with the read byte together with the start request, and it changes the wait line only at falling clock edges, each change held for at least one full cycle.

// File: rtl/epp_host_pkg.sv
// Package: shared types for the EPP host controller.
// Assumes: one transfer in flight at a time.
package epp_host_pkg;

    // Phases of a port transfer
    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_SETUP   = 3'd1,
        PH_STROBE  = 3'd2,
        PH_TERM    = 3'd3,
        PH_RELEASE = 3'd4
    } epp_phase_e;

    // A latched local request
    typedef struct packed {
        logic       is_addr;
        logic       is_read;
        logic [7:0] wbyte;
    } epp_cmd_t;

endpackage

// File: rtl/epp_sync.sv
// Module: multi-stage synchroniser for a vector of asynchronous inputs.
// Assumes: each bit is independent, and no bus coherence is needed.
module epp_sync #(
    parameter int          WIDTH    = 2,
    parameter int          STAGES   = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // shift one stage along the chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    chain[g] <= RST_VAL;
                end else if (g == 0) begin
                    chain[g] <= async_i;
                end else begin
                    chain[g] <= chain[(g == 0) ? 0 : g-1];
                end
            end
        end
    endgenerate

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/epp_rise_pulse.sv
// Module: turns a synchronised level into a one-cycle pulse on its rising edge.
// Assumes: the input is already synchronous to clk.
module epp_rise_pulse (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic pulse_o
);

    logic level_q;

    // remember the previous level
    always_ff @(posedge clk) begin
        if (!rst_n) level_q <= 1'b0;
        else        level_q <= level_i;
    end

    assign pulse_o = level_i & ~level_q;

    assert_pulse_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |=> !pulse_o);

endmodule

// File: rtl/epp_wait_timer.sv
// Module: counts the cycles spent in a wait phase and flags when the limit is reached.
// Assumes: a zero limit disables the timer and the limit is steady during a run.
module epp_wait_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          run_i,
    input  logic [TW-1:0] limit_i,
    output logic          expire_o
);

    logic [TW-1:0] cnt_q;

    // cycle counter for the current wait phase
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) cnt_q <= '0;
        else if (run_i)        cnt_q <= cnt_q + 1'b1;
    end

    assign expire_o = run_i && (limit_i != '0) && (cnt_q == limit_i - 1'b1);

    assert_count_in_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && limit_i != '0) |-> (cnt_q < limit_i));

endmodule

// File: rtl/epp_cycle_fsm.sv
// Module: sequences one EPP transfer through setup, strobe, termination and release.
// Assumes: the wait input is synchronised and a request lasts one cycle.
module epp_cycle_fsm
    import epp_host_pkg::*;
#(
    parameter int DW = 8,
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic          req_addr,
    input  logic          req_read,
    input  logic [DW-1:0] req_wdata,
    input  logic          nwait_s,
    input  logic          expire_i,
    input  logic [DW-1:0] pd_i,
    output logic          tmr_clear,
    output logic          tmr_run,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          timeout_flag,
    output logic          nwrite_o,
    output logic          ndatastb_o,
    output logic          naddrstb_o,
    output logic [DW-1:0] pd_o,
    output logic          pd_oe
);

    epp_phase_e    phase_q, phase_d;
    logic          is_addr_q, is_read_q;
    logic [DW-1:0] wbyte_q;
    logic          accept, ack, released, strobe_on;

    assign accept    = (phase_q == PH_IDLE) && req_start && !nwait_s;
    assign ack       = (phase_q == PH_STROBE) && nwait_s;
    assign released  = (phase_q == PH_TERM) && !nwait_s;
    assign strobe_on = (phase_q == PH_STROBE);

    // next phase of the transfer
    always_comb begin
        phase_d = phase_q;
        unique case (phase_q)
            PH_IDLE:    if (accept) phase_d = PH_SETUP;
            PH_SETUP:   phase_d = PH_STROBE;
            PH_STROBE:  if (nwait_s) phase_d = PH_TERM;
                        else if (expire_i) phase_d = PH_RELEASE;
            PH_TERM:    if (!nwait_s || expire_i) phase_d = PH_IDLE;
            PH_RELEASE: phase_d = PH_IDLE;
            default:    phase_d = PH_IDLE;
        endcase
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase_q <= PH_IDLE;
        else        phase_q <= phase_d;
    end

    // latch the request when it is accepted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            is_addr_q <= 1'b0;
            is_read_q <= 1'b1;
            wbyte_q   <= '0;
        end else if (accept) begin
            is_addr_q <= req_addr;
            is_read_q <= req_read;
            wbyte_q   <= req_wdata;
        end
    end

    // capture read byte and pulse done on acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            done    <= 1'b0;
        end else begin
            done <= ack;
            if (ack && is_read_q) rd_data <= pd_i;
        end
    end

    // sticky timeout flag, cleared by the next accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)                                    timeout_flag <= 1'b0;
        else if (accept)                               timeout_flag <= 1'b0;
        else if (strobe_on && !nwait_s && expire_i)    timeout_flag <= 1'b1;
        else if (phase_q == PH_TERM && nwait_s && expire_i) timeout_flag <= 1'b1;
    end

    assign tmr_clear  = (phase_q == PH_SETUP) || ack;
    assign tmr_run    = strobe_on || (phase_q == PH_TERM);
    assign busy       = (phase_q != PH_IDLE);
    assign nwrite_o   = !(busy && !is_read_q);
    assign pd_oe      = busy && !is_read_q;
    assign pd_o       = wbyte_q;
    assign naddrstb_o = !(strobe_on && is_addr_q);
    assign ndatastb_o = !(strobe_on && !is_addr_q);

    logic strobe_any;
    assign strobe_any = !ndatastb_o || !naddrstb_o;

    assert_one_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ndatastb_o && !naddrstb_o));

    assert_no_accept_wait_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q == PH_IDLE && nwait_s) |=> (phase_q == PH_IDLE));

    assert_request_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_q != PH_IDLE) |=> $stable(wbyte_q) && $stable(is_read_q) && $stable(is_addr_q));

    assert_setup_before_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strobe_any) |-> $stable(nwrite_o) && $stable(pd_oe));

    assert_write_data_held_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_any && $past(strobe_any)) |-> $stable(pd_o));

    assert_done_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_dir_change_after_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(nwrite_o) || !$stable(pd_oe)) |-> $past(ndatastb_o && naddrstb_o));

    assert_timeout_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (timeout_flag && !accept) |=> timeout_flag);

endmodule

// File: rtl/epp_host_ctrl.sv
// Module: top of the EPP host controller; synchronises port inputs and
// drives the port handshake for one local request at a time.
// Assumes: the bus pad (tri-state) lives outside, driven by pd_o and pd_oe.
module epp_host_ctrl #(
    parameter int DW          = 8,
    parameter int TW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_start,
    input  logic          req_addr,
    input  logic          req_read,
    input  logic [DW-1:0] req_wdata,
    input  logic [TW-1:0] timeout_limit,
    input  logic          periph_rst_req,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rd_data,
    output logic          timeout_flag,
    output logic          intr_pulse,
    output logic          nwrite_o,
    output logic          ndatastb_o,
    output logic          naddrstb_o,
    output logic          nreset_o,
    output logic [DW-1:0] pd_o,
    output logic          pd_oe,
    input  logic [DW-1:0] pd_i,
    input  logic          nwait_i,
    input  logic          intr_i
);

    localparam logic [1:0] SYNC_RST = 2'b01; // wait inactive, interrupt low

    logic [1:0] sync_q;
    logic       nwait_s, intr_s;
    logic       tmr_clear, tmr_run, expire;

    epp_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({intr_i, nwait_i}),
        .sync_o  (sync_q)
    );
    assign nwait_s = sync_q[0];
    assign intr_s  = sync_q[1];

    epp_rise_pulse u_intr (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (intr_s),
        .pulse_o (intr_pulse)
    );

    epp_wait_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (tmr_clear),
        .run_i    (tmr_run),
        .limit_i  (timeout_limit),
        .expire_o (expire)
    );

    epp_cycle_fsm #(.DW(DW), .TW(TW)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_start    (req_start),
        .req_addr     (req_addr),
        .req_read     (req_read),
        .req_wdata    (req_wdata),
        .nwait_s      (nwait_s),
        .expire_i     (expire),
        .pd_i         (pd_i),
        .tmr_clear    (tmr_clear),
        .tmr_run      (tmr_run),
        .busy         (busy),
        .done         (done),
        .rd_data      (rd_data),
        .timeout_flag (timeout_flag),
        .nwrite_o     (nwrite_o),
        .ndatastb_o   (ndatastb_o),
        .naddrstb_o   (naddrstb_o),
        .pd_o         (pd_o),
        .pd_oe        (pd_oe)
    );

    // peripheral reset output, low during local reset
    always_ff @(posedge clk) begin
        if (!rst_n) nreset_o <= 1'b0;
        else        nreset_o <= ~periph_rst_req;
    end

    assert_nreset_follows_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (nreset_o == !$past(periph_rst_req)));

endmodule

// File: tb/epp_host_ctrl_tb_top.sv
// Bench: a table of transfers walked by one loop, then directed corner tests.
module epp_host_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 8;
    localparam logic [7:0] NO_ACK = 8'hFF;

    typedef struct packed {
        logic       addr;
        logic       read;
        logic [7:0] wbyte;
        logic [7:0] pbyte;
        logic [7:0] ack_dly;
        logic [7:0] limit;
    } vec_t;

    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b0, 8'hA5, 8'h00, 8'd1,  8'd20},
        '{1'b1, 1'b0, 8'h3C, 8'h00, 8'd0,  8'd20},
        '{1'b0, 1'b1, 8'h00, 8'h5A, 8'd2,  8'd20},
        '{1'b1, 1'b1, 8'h00, 8'hC3, 8'd3,  8'd20},
        '{1'b0, 1'b0, 8'h11, 8'h00, NO_ACK, 8'd4},
        '{1'b0, 1'b1, 8'h00, 8'h7E, 8'd4,  8'd20},
        '{1'b1, 1'b0, 8'hFF, 8'h00, NO_ACK, 8'd1},
        '{1'b0, 1'b1, 8'h00, 8'h81, 8'd40, 8'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_start = 1'b0, req_addr = 1'b0, req_read = 1'b0;
    logic [7:0] req_wdata = '0, timeout_limit = 8'd20, pd_i = '0;
    logic       periph_rst_req = 1'b0, nwait_i = 1'b1, intr_i = 1'b0;
    logic       busy, done, timeout_flag, intr_pulse;
    logic       nwrite_o, ndatastb_o, naddrstb_o, nreset_o, pd_oe;
    logic [7:0] rd_data, pd_o;

    int n_checks = 0, n_fail = 0, done_cnt = 0, intr_cnt = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_host_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
        .req_read(req_read), .req_wdata(req_wdata), .timeout_limit(timeout_limit),
        .periph_rst_req(periph_rst_req), .busy(busy), .done(done), .rd_data(rd_data),
        .timeout_flag(timeout_flag), .intr_pulse(intr_pulse), .nwrite_o(nwrite_o),
        .ndatastb_o(ndatastb_o), .naddrstb_o(naddrstb_o), .nreset_o(nreset_o),
        .pd_o(pd_o), .pd_oe(pd_oe), .pd_i(pd_i), .nwait_i(nwait_i), .intr_i(intr_i)
    );

    // count one-cycle pulses seen at falling edges
    always @(negedge clk) begin
        if (done)       done_cnt++;
        if (intr_pulse) intr_cnt++;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic bit strobe_low();
        return !ndatastb_o || !naddrstb_o;
    endfunction

    task automatic run_vec(input vec_t v);
        int d0, lows, highs;
        bit timed;
        timed = (v.ack_dly == NO_ACK);
        d0 = done_cnt;
        @(negedge clk);
        req_addr = v.addr; req_read = v.read; req_wdata = v.wbyte;
        pd_i = v.pbyte; timeout_limit = v.limit; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        // setup cycle: direction set, strobe still high (R3, R4)
        chk(busy && !strobe_low(), "R3 setup strobe high", {busy, strobe_low()}, 2);
        chk(nwrite_o == v.read, "R4 setup nwrite", nwrite_o, v.read);
        chk(pd_oe == !v.read, "R4 setup oe", pd_oe, !v.read);
        if (!v.read) chk(pd_o == v.wbyte, "R3 setup data", pd_o, v.wbyte);
        chk(timeout_flag == 1'b0, "R10 flag cleared on accept", timeout_flag, 0);
        @(negedge clk);
        // strobe selection (R5)
        chk(ndatastb_o == v.addr && naddrstb_o == !v.addr, "R5 strobe select",
            {ndatastb_o, naddrstb_o}, {v.addr, !v.addr});
        if (timed) begin
            lows = 1;
            for (int k = 0; k < 40; k++) begin
                @(negedge clk);
                if (!strobe_low()) break;
                lows++;
            end
            chk(lows == v.limit, "R7 strobe low cycles", lows, v.limit);
            for (int k = 0; k < 6 && busy; k++) @(negedge clk);
            chk(!busy && timeout_flag, "R7 timeout idle", {busy, timeout_flag}, 1);
            chk(!pd_oe && nwrite_o, "R7 bus released", {pd_oe, nwrite_o}, 1);
            chk(done_cnt == d0, "R7 no done", done_cnt - d0, 0);
        end else begin
            highs = 0;
            for (int k = 0; k < v.ack_dly; k++) begin
                @(negedge clk);
                if (!strobe_low()) highs++;
                if (!v.read && pd_o != v.wbyte) highs++;
            end
            chk(highs == 0, "R9 R3 strobe held while waiting", highs, 0);
            nwait_i = 1'b1;
            for (int k = 0; k < 10; k++) begin
                @(negedge clk);
                if (!strobe_low()) break;
            end
            @(negedge clk);
            chk(done_cnt == d0 + 1, "R4 one done pulse", done_cnt - d0, 1);
            if (v.read) chk(rd_data == v.pbyte, "R4 read byte", rd_data, v.pbyte);
            chk(busy && nwrite_o == v.read && pd_oe == !v.read, "R6 held after strobe",
                {busy, nwrite_o, pd_oe}, {1'b1, v.read, !v.read});
            nwait_i = 1'b0;
            for (int k = 0; k < 6 && busy; k++) @(negedge clk);
            chk(!busy && nwrite_o && !pd_oe, "R6 idle after release",
                {busy, nwrite_o, pd_oe}, 3'b010);
            chk(timeout_flag == 1'b0, "R9 no timeout", timeout_flag, 0);
        end
        repeat (2) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int d0, i0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ndatastb_o && naddrstb_o && nwrite_o && !pd_oe, "R1 port idle in reset",
            {ndatastb_o, naddrstb_o, nwrite_o, pd_oe}, 4'b1110);
        chk(!busy && !timeout_flag && !nreset_o, "R1 status in reset",
            {busy, timeout_flag, nreset_o}, 0);
        rst_n = 1'b1;
        nwait_i = 1'b1;
        repeat (4) @(negedge clk);
        // R2 start ignored while wait high
        req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !strobe_low(), "R2 ignored with wait high", {busy, strobe_low()}, 0);
        nwait_i = 1'b0;
        repeat (3) @(negedge clk);

        for (int i = 0; i < NVEC; i++) run_vec(VECS[i]);

        // R10 sticky flag: timeout, then idle cycles with no start
        run_vec('{1'b0, 1'b0, 8'h22, 8'h00, NO_ACK, 8'd3});
        repeat (5) @(negedge clk);
        chk(timeout_flag, "R10 flag sticky", timeout_flag, 1);

        // R2 start ignored while busy
        d0 = done_cnt;
        timeout_limit = 8'd20;
        req_addr = 1'b0; req_read = 1'b0; req_wdata = 8'h6B; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        @(negedge clk);
        req_wdata = 8'h99; req_addr = 1'b1; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        chk(pd_o == 8'h6B && !ndatastb_o && naddrstb_o, "R2 busy start ignored",
            pd_o, 8'h6B);
        nwait_i = 1'b1;
        repeat (4) @(negedge clk);
        nwait_i = 1'b0;
        repeat (5) @(negedge clk);
        chk(!busy && done_cnt == d0 + 1, "R2 only one transfer", done_cnt - d0, 1);

        // R8 timeout after strobe release
        req_read = 1'b1; req_addr = 1'b1; timeout_limit = 8'd5; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        @(negedge clk);
        nwait_i = 1'b1;
        for (int k = 0; k < 20 && busy; k++) @(negedge clk);
        chk(!busy && timeout_flag, "R8 release timeout", {busy, timeout_flag}, 1);
        nwait_i = 1'b0;
        repeat (3) @(negedge clk);

        // R11 interrupt edges
        i0 = intr_cnt;
        intr_i = 1'b1;
        repeat (8) @(negedge clk);
        chk(intr_cnt == i0 + 1, "R11 one pulse per edge", intr_cnt - i0, 1);
        repeat (8) @(negedge clk);
        chk(intr_cnt == i0 + 1, "R11 level gives no pulse", intr_cnt - i0, 1);
        intr_i = 1'b0;
        repeat (4) @(negedge clk);
        intr_i = 1'b1;
        repeat (6) @(negedge clk);
        chk(intr_cnt == i0 + 2, "R11 second edge", intr_cnt - i0, 2);

        // R12 peripheral reset output
        periph_rst_req = 1'b1;
        @(negedge clk);
        chk(nreset_o == 1'b0, "R12 nreset low", nreset_o, 0);
        periph_rst_req = 1'b0;
        @(negedge clk);
        chk(nreset_o == 1'b1, "R12 nreset high", nreset_o, 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule